// File: doc/BRIEF.md
# Dual-Mode Pulse-Swallow Programmable Divider

This block divides a local-oscillator signal by a programmable ratio N and emits one short pulse per division cycle for a downstream phase comparator. Both oscillator inputs are modelled as single-cycle tick strobes, each one standing for one oscillator period, sampled on the block clock. The whole divider is therefore ordinary synchronous logic.

Two counting paths are available. The swallow path uses a dual-modulus prescaler that divides by 16 or 17. A 4-bit swallow counter, loaded from the low nibble of the ratio, keeps the prescaler at 17 for its first A cycles. A 12-bit main counter, loaded from the upper twelve ratio bits (B), counts prescaler wraps, so N = 16*B + A. The swallow path can take its ticks from either oscillator input. The direct path feeds ticks from the second oscillator input straight into the 12-bit counter.

The ratio word and the path selection are captured only when a division cycle completes, or on the first clock after reset or inhibit. An inhibit input stops the divider and clears its state.

Top module: `pswallow_divider`

## Requirements
- R1: While `rst_n` is low, and in the first clock after it rises, `div_pulse` is 0. The first clock with `rst_n` high and `inhibit` low captures the configuration, and any tick in that clock is not counted.
- R2: With `band_hi`=1, the divider counts only `osc_hi_tick` and N is the full 16-bit `ratio_word`. Ticks on `osc_lo_tick` have no effect.
- R3: With `band_hi`=0 and `lo_swallow`=1, the divider counts only `osc_lo_tick` and N is the full 16-bit `ratio_word`. Ticks on `osc_hi_tick` have no effect.
- R4: With `band_hi`=0 and `lo_swallow`=0 (direct path), the divider counts only `osc_lo_tick` and N = `ratio_word[15:4]`. Bits 3:0 have no effect.
- R5: On a swallow path, a ratio below 272 is used as 272.
- R6: On the direct path, an N field below 4 is used as 4.
- R7: In the clock after the Nth counted tick, `div_pulse` is 1 for exactly one clock. It is 0 in every other clock.
- R8: A change of `ratio_word`, `band_hi` or `lo_swallow` takes effect at the next completed division cycle. The cycle already in progress finishes with the old ratio.
- R9: While `inhibit` is 1, `div_pulse` stays 0 and all counting state is cleared. After release, the first clock loads the configuration and the next N ticks produce a pulse.
- R10: On a swallow path with B = ratio[15:4] and A = ratio[3:0], the prescaler divides by 17 for A of its cycles and by 16 for the remaining B-A cycles. The total is exactly 16*B + A ticks, for every A from 0 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_hi_tick | input | 1 | One tick per period of the first (high-band) oscillator |
| osc_lo_tick | input | 1 | One tick per period of the second oscillator |
| ratio_word | input | 16 | Division ratio word |
| band_hi | input | 1 | 1 selects the first oscillator on the swallow path |
| lo_swallow | input | 1 | With band_hi=0: 1 selects swallow, 0 selects direct division |
| inhibit | input | 1 | 1 stops the divider and clears its state |
| div_pulse | output | 1 | One-clock pulse per completed division cycle |

## Verification
The assertions assume that each tick input carries at most one oscillator period per block clock. They also assume that the configuration is captured only at a load, so the swallow remainder stays below the main remainder for the whole cycle. The bench drives the ticks as single-cycle strobes, either every clock or at random. It changes ratio and mode words only on the falling clock edge. It mixes configuration changes made in the middle of a cycle with inhibit windows, so every load path is exercised. A behavioural model counts ticks down from N and predicts every pulse without reference to prescaler structure.

// File: rtl/pswallow_pkg.sv
// Shared types for the pulse-swallow divider.
package pswallow_pkg;
    // Counting path selected for the current division cycle.
    typedef enum logic [1:0] {
        PATH_HI_SWALLOW = 2'd0,
        PATH_LO_SWALLOW = 2'd1,
        PATH_LO_DIRECT  = 2'd2
    } path_e;
endpackage

// File: rtl/psd_ratio_decode.sv
// Decodes the ratio word and select bits into a path, a swallow count A and
// a main count B, with clamping to the legal minimum of each path.
// Assumes RATIO_W > SW_W and that the minimum swallow ratio fits RATIO_W.
module psd_ratio_decode
    import pswallow_pkg::*;
#(
    parameter int RATIO_W    = 16,
    parameter int SW_W       = 4,
    parameter int MIN_DIRECT = 4
) (
    input  logic [RATIO_W-1:0]       ratio_word,
    input  logic                     band_hi,
    input  logic                     lo_swallow,
    output path_e                    path,
    output logic [SW_W-1:0]          swallow_a,
    output logic [RATIO_W-SW_W-1:0]  main_b
);
    localparam int MAIN_W      = RATIO_W - SW_W;
    localparam int MIN_SWALLOW = (1 << SW_W) * ((1 << SW_W) + 1);
    localparam logic [RATIO_W-1:0] MIN_SW_V  = RATIO_W'(MIN_SWALLOW);
    localparam logic [MAIN_W-1:0]  MIN_DIR_V = MAIN_W'(MIN_DIRECT);

    logic [RATIO_W-1:0] sw_ratio;
    logic [MAIN_W-1:0]  dir_field;

    // Path choice and clamped counts
    always_comb begin
        sw_ratio  = (ratio_word < MIN_SW_V) ? MIN_SW_V : ratio_word;
        dir_field = ratio_word[RATIO_W-1:SW_W];
        if (band_hi)         path = PATH_HI_SWALLOW;
        else if (lo_swallow) path = PATH_LO_SWALLOW;
        else                 path = PATH_LO_DIRECT;
        if (path == PATH_LO_DIRECT) begin
            swallow_a = '0;
            main_b    = (dir_field < MIN_DIR_V) ? MIN_DIR_V : dir_field;
        end else begin
            swallow_a = sw_ratio[SW_W-1:0];
            main_b    = sw_ratio[RATIO_W-1:SW_W];
        end
    end
endmodule

// File: rtl/psd_prescaler.sv
// Dual-modulus prescaler: divides ticks by 2^SW_W, or by 2^SW_W+1 while
// 'extend' is high. In bypass every tick is a wrap (direct division).
// Assumes 'extend' changes only on a wrap or a restart.
module psd_prescaler #(
    parameter int SW_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic tick,
    input  logic bypass,
    input  logic extend,
    output logic wrap
);
    localparam int CW = SW_W + 1;
    localparam logic [CW-1:0] LAST_BASE = CW'((1 << SW_W) - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    assign last = extend ? (LAST_BASE + CW'(1)) : LAST_BASE;
    assign wrap = tick && (bypass || (cnt == last));

    // Modulus counter for the prescaler
    always_ff @(posedge clk) begin
        if (!rst_n || restart)      cnt <= '0;
        else if (tick && !bypass)   cnt <= (cnt == last) ? '0 : cnt + CW'(1);
    end
endmodule

// File: rtl/psd_swallow_ctr.sv
// Swallow counter: holds the number of prescaler cycles still to run at the
// extended modulus. Counts down once per prescaler wrap and stops at zero.
module psd_swallow_ctr #(
    parameter int SW_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            load,
    input  logic [SW_W-1:0] load_val,
    input  logic            dec,
    output logic            active,
    output logic [SW_W-1:0] left
);
    assign active = (left != '0);

    // Load, clear or count down the swallow remainder
    always_ff @(posedge clk) begin
        if (!rst_n || clr)         left <= '0;
        else if (load)             left <= load_val;
        else if (dec && active)    left <= left - SW_W'(1);
    end
endmodule

// File: rtl/psd_main_ctr.sv
// Main counter: holds the prescaler cycles left in the division cycle.
// 'last' flags the final one. Assumes a load value of at least 1.
module psd_main_ctr #(
    parameter int MAIN_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [MAIN_W-1:0] load_val,
    input  logic              dec,
    output logic              last,
    output logic [MAIN_W-1:0] left
);
    assign last = (left == MAIN_W'(1));

    // Load, clear or count down the main remainder
    always_ff @(posedge clk) begin
        if (!rst_n || clr)               left <= '0;
        else if (load)                   left <= load_val;
        else if (dec && left != '0)      left <= left - MAIN_W'(1);
    end
endmodule

// File: rtl/pswallow_divider.sv
// Dual-mode pulse-swallow divider top. It selects the tick source from the
// latched path, runs prescaler, swallow and main counters, and captures a
// fresh configuration at each terminal count or after reset or inhibit.
// Assumes at most one tick per clock on each oscillator input.
module pswallow_divider
    import pswallow_pkg::*;
#(
    parameter int RATIO_W    = 16,
    parameter int SW_W       = 4,
    parameter int MIN_DIRECT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               osc_hi_tick,
    input  logic               osc_lo_tick,
    input  logic [RATIO_W-1:0] ratio_word,
    input  logic               band_hi,
    input  logic               lo_swallow,
    input  logic               inhibit,
    output logic               div_pulse
);
    localparam int MAIN_W = RATIO_W - SW_W;

    path_e             nxt_path;
    logic [SW_W-1:0]   nxt_a;
    logic [MAIN_W-1:0] nxt_b;
    path_e             cur_path;
    logic              need_load;
    logic              path_direct;
    logic              tick_sel;
    logic              run_tick;
    logic              pre_wrap;
    logic              sw_active;
    logic [SW_W-1:0]   sw_left;
    logic              main_last;
    logic [MAIN_W-1:0] main_left;
    logic              terminal;
    logic              load;

    psd_ratio_decode #(
        .RATIO_W(RATIO_W), .SW_W(SW_W), .MIN_DIRECT(MIN_DIRECT)
    ) u_decode (
        .ratio_word(ratio_word), .band_hi(band_hi), .lo_swallow(lo_swallow),
        .path(nxt_path), .swallow_a(nxt_a), .main_b(nxt_b)
    );

    assign path_direct = (cur_path == PATH_LO_DIRECT);
    assign tick_sel    = (cur_path == PATH_HI_SWALLOW) ? osc_hi_tick : osc_lo_tick;
    assign run_tick    = tick_sel && !inhibit && !need_load;
    assign terminal    = pre_wrap && main_last;
    assign load        = (!inhibit && need_load) || terminal;

    psd_prescaler #(.SW_W(SW_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(inhibit || load),
        .tick(run_tick), .bypass(path_direct), .extend(sw_active),
        .wrap(pre_wrap)
    );

    psd_swallow_ctr #(.SW_W(SW_W)) u_swallow (
        .clk(clk), .rst_n(rst_n), .clr(inhibit), .load(load),
        .load_val(nxt_a), .dec(pre_wrap), .active(sw_active), .left(sw_left)
    );

    psd_main_ctr #(.MAIN_W(MAIN_W)) u_main (
        .clk(clk), .rst_n(rst_n), .clr(inhibit), .load(load),
        .load_val(nxt_b), .dec(pre_wrap), .last(main_last), .left(main_left)
    );

    // Latch the path for the cycle that a load starts
    always_ff @(posedge clk) begin
        if (!rst_n)    cur_path <= PATH_HI_SWALLOW;
        else if (load) cur_path <= nxt_path;
    end

    // Track whether a configuration capture is pending
    always_ff @(posedge clk) begin
        if (!rst_n) need_load <= 1'b1;
        else        need_load <= inhibit;
    end

    // Emit one pulse per completed division cycle
    always_ff @(posedge clk) begin
        if (!rst_n) div_pulse <= 1'b0;
        else        div_pulse <= terminal;
    end
endmodule

// File: rtl/pswallow_divider_chk.sv
// Property checker for the pulse-swallow divider, attached by bind.
// Assumes single-cycle tick strobes on the oscillator inputs.
module pswallow_divider_chk #(
    parameter int SW_W   = 4,
    parameter int MAIN_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              osc_hi_tick,
    input logic              osc_lo_tick,
    input logic              inhibit,
    input logic              div_pulse,
    input logic              path_direct,
    input logic [SW_W-1:0]   sw_left,
    input logic [MAIN_W-1:0] main_left
);
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

    a_r7_pulse_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |-> $past(osc_hi_tick || osc_lo_tick));

    a_r9_inhibit_silent: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |=> !div_pulse);

    a_r10_swallow_below_main: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_left != '0) |-> (main_left > MAIN_W'(sw_left)));

    a_r4_direct_no_swallow: assert property (@(posedge clk) disable iff (!rst_n)
        path_direct |-> (sw_left == '0));
endmodule

bind pswallow_divider pswallow_divider_chk #(.SW_W(SW_W), .MAIN_W(MAIN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .osc_hi_tick(osc_hi_tick), .osc_lo_tick(osc_lo_tick),
    .inhibit(inhibit), .div_pulse(div_pulse), .path_direct(path_direct),
    .sw_left(sw_left), .main_left(main_left)
);

// File: tb/pswallow_divider_bench.sv
module pswallow_divider_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_hi_tick = 1'b0;
    logic        osc_lo_tick = 1'b0;
    logic [15:0] ratio_word = 16'd272;
    logic        band_hi = 1'b1;
    logic        lo_swallow = 1'b0;
    logic        inhibit = 1'b0;
    logic        div_pulse;

    int    checks = 0;
    int    failures = 0;
    string phase = "R1";
    int    hi_mode = 0;   // 0 idle, 1 every clock, 2 random
    int    lo_mode = 0;
    bit    cmp_en = 0;
    bit    finished = 0;

    always #4 clk = ~clk;

    pswallow_divider u_pswallow_divider (
        .clk(clk), .rst_n(rst_n), .osc_hi_tick(osc_hi_tick), .osc_lo_tick(osc_lo_tick),
        .ratio_word(ratio_word), .band_hi(band_hi), .lo_swallow(lo_swallow),
        .inhibit(inhibit), .div_pulse(div_pulse)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Tick drivers
    always @(negedge clk) begin
        osc_hi_tick <= (hi_mode == 1) || (hi_mode == 2 && ($urandom_range(0, 1) == 1));
        osc_lo_tick <= (lo_mode == 1) || (lo_mode == 2 && ($urandom_range(0, 1) == 1));
    end

    // Behavioural reference: a tick count-down from N
    bit m_need = 1, m_hi = 1, exp_pulse = 0;
    int m_left = 0;

    function automatic int model_n();
        int n;
        if (band_hi || lo_swallow) begin
            n = ratio_word;
            if (n < 272) n = 272;
        end else begin
            n = ratio_word >> 4;
            if (n < 4) n = 4;
        end
        return n;
    endfunction

    always @(posedge clk) begin
        if (!rst_n || inhibit) begin
            m_need = 1; exp_pulse = 0;
        end else if (m_need) begin
            m_need = 0; exp_pulse = 0; m_hi = band_hi; m_left = model_n();
        end else begin
            exp_pulse = 0;
            if (m_hi ? osc_hi_tick : osc_lo_tick) begin
                m_left--;
                if (m_left == 0) begin
                    exp_pulse = 1; m_hi = band_hi; m_left = model_n();
                end
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_en) check(div_pulse == exp_pulse, phase, int'(div_pulse), int'(exp_pulse));
    end

    task automatic next_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!div_pulse && n < 70000);
    endtask

    task automatic gap_check(input int expv, input string req);
        int g;
        next_pulse(g);
        next_pulse(g);
        check(g == expv, req, g, expv);
    endtask

    task automatic set_cfg(input logic [15:0] r, input logic bh, input logic ls);
        @(negedge clk);
        ratio_word = r; band_hi = bh; lo_swallow = ls;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=0 expected=1");
        summary();
    end

    initial begin
        int g;
        int cnt;
        // R1: reset state
        repeat (5) @(negedge clk);
        check(div_pulse == 1'b0, "R1", int'(div_pulse), 0);
        hi_mode = 1; lo_mode = 2;
        rst_n = 1'b1;
        @(negedge clk);
        check(div_pulse == 1'b0, "R1", int'(div_pulse), 0);
        cmp_en = 1;
        // R1: first pulse after load clock plus 272 ticks
        next_pulse(g);
        check(g == 272, "R1", g, 272);

        // R2 / R5: first oscillator, minimum ratio, lo ticks ignored
        phase = "R2";
        gap_check(272, "R2");
        set_cfg(16'd4096, 1'b1, 1'b0);
        next_pulse(g);
        gap_check(4096, "R2");
        // R10: A = 15
        phase = "R10";
        set_cfg(16'h01FF, 1'b1, 1'b0);
        next_pulse(g);
        gap_check(511, "R10");
        set_cfg(16'h0121, 1'b1, 1'b0);
        next_pulse(g);
        gap_check(289, "R10");
        // R5: clamping
        phase = "R5";
        set_cfg(16'd100, 1'b1, 1'b0);
        next_pulse(g);
        gap_check(272, "R5");
        set_cfg(16'd0, 1'b1, 1'b0);
        next_pulse(g);
        gap_check(272, "R5");

        // R3: second oscillator swallow, hi ticks ignored
        phase = "R3";
        hi_mode = 2; lo_mode = 1;
        set_cfg(16'd1000, 1'b0, 1'b1);
        next_pulse(g);
        gap_check(1000, "R3");

        // R4: direct path, low nibble ignored
        phase = "R4";
        set_cfg(16'h0AB5, 1'b0, 1'b0);
        next_pulse(g);
        gap_check(171, "R4");
        set_cfg(16'h00FA, 1'b0, 1'b0);
        next_pulse(g);
        gap_check(15, "R4");
        // R6: direct clamp
        phase = "R6";
        set_cfg(16'h0039, 1'b0, 1'b0);
        next_pulse(g);
        gap_check(4, "R6");
        set_cfg(16'h000F, 1'b0, 1'b0);
        next_pulse(g);
        gap_check(4, "R6");

        // R7: pulse lasts one clock
        phase = "R7";
        next_pulse(g);
        @(negedge clk);
        check(div_pulse == 1'b0, "R7", int'(div_pulse), 0);

        // R8: change in mid-cycle waits for terminal count
        phase = "R8";
        set_cfg(16'h0320, 1'b0, 1'b0);
        next_pulse(g);
        next_pulse(g);
        repeat (10) @(negedge clk);
        ratio_word = 16'h0640;
        next_pulse(g);
        check(g + 10 == 50, "R8", g + 10, 50);
        next_pulse(g);
        check(g == 100, "R8", g, 100);

        // R9: inhibit silences and restarts
        phase = "R9";
        @(negedge clk);
        inhibit = 1'b1;
        cnt = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (div_pulse) cnt++;
        end
        check(cnt == 0, "R9", cnt, 0);
        inhibit = 1'b0;
        next_pulse(g);
        check(g == 101, "R9", g, 101);

        // R3: random ticks on second oscillator, model compared every clock
        phase = "R3";
        lo_mode = 2; hi_mode = 1;
        set_cfg(16'd300, 1'b0, 1'b1);
        repeat (4000) @(negedge clk);
        // R2: random ticks on first oscillator
        phase = "R2";
        hi_mode = 2; lo_mode = 1;
        set_cfg(16'd290, 1'b1, 1'b0);
        repeat (4000) @(negedge clk);

        summary();
    end
endmodule